// File: doc/BRIEF.md
# Fixed-Priority Core Interrupt Controller

This block sits directly in front of a processor core and reduces a set of interrupt sources to one request. On every clock it reports the number of the most urgent level that is asking for service, together with a valid flag. There are sixteen level numbers. Level 0 is the reset request and level 1 is the non-maskable interrupt. Levels 2 and 3 are reserved, so they have no input and are never reported. The twelve levels 4 to 15 take sources from outside the core, and each of them passes through an enable bit.

The reset request is level-sensitive and is not stored. The non-maskable interrupt and each external level are caught on the rising edge of their input. The request then stays pending until the core acknowledges it. To acknowledge, the core pulses an acknowledge strobe and gives the level number with it. The enable bits come from outside the block. A disabled level keeps its pending flag, and the level is reported once its enable bit is set again. Both outputs are registered.

Top module: `core_irq_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `irq_valid_o` is 0 and `irq_level_o` is 0, and no request is pending.
- R2: Whenever `rst_req_i` was high at the previous clock edge, the outputs show valid with level 0, whatever else is pending. The request is not latched, and an acknowledge of level 0 has no effect.
- R3: A rising edge on `nmi_req_i` makes level 1 pending. Level 1 ignores the enable bits, outranks every external level, and stays pending until an acknowledge of level 1.
- R4: Levels 2 and 3 are never reported, and an acknowledge that names them changes nothing.
- R5: A rising edge on `ext_req_i[k]` makes level 4+k pending. The flag stays set after the input falls and keeps being reported until that level is acknowledged.
- R6: Among the external levels, the smallest pending and enabled level number is reported (4 highest, 15 lowest). When nothing is eligible, the outputs show valid 0 and level 0.
- R7: When `ext_en_i[k]` is 0, level 4+k is not reported but stays pending. Once the bit is set again, the level is reported one clock later.
- R8: An acknowledge strobe with `ack_level_i` = L clears only the pending flag of level L, at the same clock edge. If a new rising edge of that level arrives in the same cycle, the flag stays set.
- R9: A change at an input becomes visible at the outputs exactly one clock edge later, and not before that edge.
- R10: An acknowledge of a level that is not pending leaves every output and every other pending flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the block |
| rst_req_i | input | 1 | Core reset request, level 0, level-sensitive |
| nmi_req_i | input | 1 | Non-maskable request, level 1, rising-edge |
| ext_req_i | input | 12 | External requests; bit k feeds level 4+k, rising-edge |
| ext_en_i | input | 12 | Enable bits; bit k gates level 4+k |
| ack_i | input | 1 | Acknowledge strobe, one cycle |
| ack_level_i | input | 4 | Level number being acknowledged |
| irq_valid_o | output | 1 | A request is being reported |
| irq_level_o | output | 4 | Number of the reported level (0 when not valid) |

## Verification
The bench builds the block with the default sixteen levels, where the external group starts at level 4. With these values all twelve external lines fit in a short run. Every ordered pair of external lines is swept, and for each pair the higher-numbered partner is shown to appear once the winner is acknowledged. Every enable bit is taken through the disable, edge and re-enable sequence. All sixteen acknowledge codes are applied against a fixed pending set, so the ignored codes 0, 2 and 3 are covered alongside the active ones.

// File: rtl/core_irq_pkg.sv
`timescale 1ns/1ps
package core_irq_pkg;

    // Level numbers with a fixed meaning at the top of the priority order.
    localparam int unsigned LVL_RESET = 0;
    localparam int unsigned LVL_NMI   = 1;

    // Slot 0 of the pending bank holds the NMI; slot s>0 holds external
    // level ext_base+s-1.
    function automatic int unsigned slot_to_level(input int unsigned slot,
                                                  input int unsigned ext_base);
        if (slot == 0) begin
            return LVL_NMI;
        end
        return ext_base + slot - 1;
    endfunction

endpackage

// File: rtl/irq_ack_decode.sv
`timescale 1ns/1ps
module irq_ack_decode #(
    parameter int unsigned EXT_BASE = 4,
    parameter int unsigned SLOTS    = 13,
    parameter int unsigned LVL_W    = 4
) (
    input  logic             ack_i,
    input  logic [LVL_W-1:0] ack_level_i,
    output logic [SLOTS-1:0] clr_o
);
    import core_irq_pkg::*;

    // One comparator per latched slot; codes without a slot match nothing.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        localparam int unsigned SLOT_LVL = slot_to_level(s, EXT_BASE);
        assign clr_o[s] = ack_i && (ack_level_i == LVL_W'(SLOT_LVL));
    end

endmodule

// File: rtl/irq_pend_bank.sv
`timescale 1ns/1ps
module irq_pend_bank #(
    parameter int unsigned WIDTH = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] req_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] pend_d_o,
    output logic [WIDTH-1:0] pend_q_o
);

    typedef struct packed {
        logic [WIDTH-1:0] prev;
        logic [WIDTH-1:0] pend;
    } bank_t;

    bank_t            st_d;
    bank_t            st_q;
    logic [WIDTH-1:0] rise;

    always_comb begin
        st_d      = st_q;
        rise      = req_i & ~st_q.prev;
        st_d.prev = req_i;
        // A fresh edge wins over a clear that lands in the same cycle.
        st_d.pend = rise | (st_q.pend & ~clr_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_d_o = st_d.pend;
    assign pend_q_o = st_q.pend;

    for (genvar b = 0; b < WIDTH; b++) begin : g_chk
        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[b] && !rise[b]) |=> !st_q.pend[b]);                     // R8
        AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.pend[b] && !clr_i[b]) |=> st_q.pend[b]);                 // R5
        AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            rise[b] |=> st_q.pend[b]);                                     // R8
    end

endmodule

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
module irq_prio_pick #(
    parameter int unsigned NUM_LEVELS = 16,
    parameter int unsigned LVL_W      = 4
) (
    input  logic [NUM_LEVELS-1:0] elig_i,
    output logic                  valid_o,
    output logic [LVL_W-1:0]      level_o
);

    // Scan from the lowest priority upward so the smallest index is kept last.
    always_comb begin
        valid_o = 1'b0;
        level_o = '0;
        for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
            if (elig_i[i]) begin
                valid_o = 1'b1;
                level_o = LVL_W'(i);
            end
        end
    end

endmodule

// File: rtl/core_irq_ctrl.sv
`timescale 1ns/1ps
module core_irq_ctrl #(
    parameter int unsigned NUM_LEVELS = 16,
    parameter int unsigned EXT_BASE   = 4,
    localparam int unsigned EXT_COUNT = NUM_LEVELS - EXT_BASE,
    localparam int unsigned LVL_W     = $clog2(NUM_LEVELS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rst_req_i,
    input  logic                 nmi_req_i,
    input  logic [EXT_COUNT-1:0] ext_req_i,
    input  logic [EXT_COUNT-1:0] ext_en_i,
    input  logic                 ack_i,
    input  logic [LVL_W-1:0]     ack_level_i,
    output logic                 irq_valid_o,
    output logic [LVL_W-1:0]     irq_level_o
);
    import core_irq_pkg::*;

    localparam int unsigned SLOTS  = EXT_COUNT + 1;
    localparam int unsigned SLOT_W = $clog2(SLOTS);

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] level;
    } out_t;

    logic [SLOTS-1:0]      slot_req;
    logic [SLOTS-1:0]      slot_clr;
    logic [SLOTS-1:0]      pend_d;
    logic [SLOTS-1:0]      pend_q;
    logic [NUM_LEVELS-1:0] elig;
    logic                  pick_valid;
    logic [LVL_W-1:0]      pick_level;
    out_t                  out_d;
    out_t                  out_q;
    logic [SLOT_W-1:0]     shown_slot;

    assign slot_req = {ext_req_i, nmi_req_i};

    irq_ack_decode #(
        .EXT_BASE (EXT_BASE),
        .SLOTS    (SLOTS),
        .LVL_W    (LVL_W)
    ) u_ack_dec (
        .ack_i       (ack_i),
        .ack_level_i (ack_level_i),
        .clr_o       (slot_clr)
    );

    irq_pend_bank #(
        .WIDTH (SLOTS)
    ) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (slot_req),
        .clr_i    (slot_clr),
        .pend_d_o (pend_d),
        .pend_q_o (pend_q)
    );

    // The selection looks at next-state pending so that the registered
    // outputs trail the inputs by a single edge.
    always_comb begin
        elig            = '0;
        elig[LVL_RESET] = rst_req_i;
        elig[LVL_NMI]   = pend_d[0];
        for (int k = 0; k < int'(EXT_COUNT); k++) begin
            elig[EXT_BASE + k] = pend_d[k + 1] & ext_en_i[k];
        end
    end

    irq_prio_pick #(
        .NUM_LEVELS (NUM_LEVELS),
        .LVL_W      (LVL_W)
    ) u_pick (
        .elig_i  (elig),
        .valid_o (pick_valid),
        .level_o (pick_level)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = pick_valid;
        out_d.level = pick_level;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign irq_valid_o = out_q.valid;
    assign irq_level_o = out_q.level;

    always_comb begin
        if (irq_level_o >= LVL_W'(EXT_BASE)) begin
            shown_slot = SLOT_W'(irq_level_o - LVL_W'(EXT_BASE) + LVL_W'(1));
        end else begin
            shown_slot = '0;
        end
    end

    AST_RSVD_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> (irq_level_o != LVL_W'(2) && irq_level_o != LVL_W'(3))); // R4
    AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_i |=> (irq_valid_o && irq_level_o == LVL_W'(LVL_RESET)));        // R2
    AST_EXT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && irq_level_o >= LVL_W'(EXT_BASE)) |-> pend_q[shown_slot]); // R5
    AST_NMI_OVER_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && irq_level_o >= LVL_W'(EXT_BASE)) |-> !pend_q[0]);        // R3
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid_o |-> irq_level_o == '0);                                     // R6

endmodule

// File: tb/core_irq_ctrl_tb.sv
`timescale 1ns/1ps
module core_irq_ctrl_tb;

    localparam int NEXT = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rst_req = 1'b0;
    logic            nmi_req = 1'b0;
    logic [NEXT-1:0] ext_req = '0;
    logic [NEXT-1:0] ext_en = '0;
    logic            ack = 1'b0;
    logic [3:0]      ack_lvl = '0;
    logic            valid;
    logic [3:0]      level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state built from the requirements.
    logic [NEXT-1:0] m_pend = '0;
    logic [NEXT-1:0] m_prev = '0;
    logic            m_npend = 1'b0;
    logic            m_nprev = 1'b0;

    always #4 clk = ~clk;

    core_irq_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rst_req_i   (rst_req),
        .nmi_req_i   (nmi_req),
        .ext_req_i   (ext_req),
        .ext_en_i    (ext_en),
        .ack_i       (ack),
        .ack_level_i (ack_lvl),
        .irq_valid_o (valid),
        .irq_level_o (level)
    );

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual valid/level=%0d/%0d expected=%0d/%0d",
                     tag, act[4], act[3:0], exp[4], exp[3:0]);
        end
    endtask

    function automatic logic [4:0] model_out();
        if (rst_req) return {1'b1, 4'd0};
        if (m_npend) return {1'b1, 4'd1};
        for (int k = 0; k < NEXT; k++) begin
            if (m_pend[k] && ext_en[k]) return {1'b1, 4'(k + 4)};
        end
        return 5'd0;
    endfunction

    // Inputs are already set (at a falling edge); advance one edge and compare.
    task automatic step(input string tag);
        logic [NEXT-1:0] clr;
        logic            nclr;
        logic [4:0]      exp;
        clr  = '0;
        nclr = ack && (ack_lvl == 4'd1);
        if (ack && ack_lvl >= 4'd4) clr[ack_lvl - 4'd4] = 1'b1;
        m_pend  = (ext_req & ~m_prev) | (m_pend & ~clr);
        m_prev  = ext_req;
        m_npend = (nmi_req & ~m_nprev) | (m_npend & ~nclr);
        m_nprev = nmi_req;
        exp = model_out();
        @(posedge clk);
        #1;
        check(tag, {valid, level}, exp);
        checks++;
        if (valid && (level == 4'd2 || level == 4'd3)) begin
            errors++;
            $display("FAIL R4 actual level=%0d expected=not 2 or 3", level);
        end
        @(negedge clk);
    endtask

    task automatic do_ack(input logic [3:0] l, input string tag);
        ack = 1'b1;
        ack_lvl = l;
        step(tag);
        ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 during reset", {valid, level}, 5'd0);
        @(negedge clk);
        rst_n = 1'b1;
        step("R1 first cycle after reset");

        // R9: nothing changes before the edge, then the change shows after it
        ext_en = '1;
        ext_req[3] = 1'b1;
        #2;
        check("R9 before edge", {valid, level}, 5'd0);
        #2;
        #1;
        check("R9 after edge", {valid, level}, {1'b1, 4'd7});
        @(negedge clk);
        m_pend[3] = 1'b1;
        m_prev[3] = 1'b1;
        ext_req = '0;
        step("R5 held after input falls");
        step("R5 held");
        do_ack(4'd7, "R8 ack clears");

        // R6: every ordered pair of external lines
        for (int i = 0; i < NEXT; i++) begin
            for (int j = 0; j < NEXT; j++) begin
                ext_req[i] = 1'b1;
                ext_req[j] = 1'b1;
                step("R6 pair winner");
                ext_req = '0;
                do_ack(4'((i < j ? i : j) + 4), "R8 partner remains");
                do_ack(4'((i < j ? j : i) + 4), "R8 second ack");
            end
        end

        // R7: each enable bit through disable, edge, re-enable
        for (int k = 0; k < NEXT; k++) begin
            ext_en = ~(NEXT'(1) << k);
            ext_req[k] = 1'b1;
            step("R7 masked not reported");
            ext_req[k] = 1'b0;
            step("R7 masked still hidden");
            ext_en = '1;
            step("R7 re-enabled reported");
            do_ack(4'(k + 4), "R8 clear after enable");
        end

        // R8: acknowledge and a new edge of the same level in one cycle
        ext_req[5] = 1'b1;
        step("R5 set level 9");
        ext_req[5] = 1'b0;
        step("R5 level 9 held");
        ext_req[5] = 1'b1;
        do_ack(4'd9, "R8 edge wins over ack");
        ext_req[5] = 1'b0;
        step("R8 still pending");
        do_ack(4'd9, "R8 cleared");

        // R3: NMI over everything external, enables ignored
        ext_req = '1;
        step("R5 all external pending");
        ext_en = '0;
        nmi_req = 1'b1;
        step("R3 nmi with mask off");
        nmi_req = 1'b0;
        ext_en = '1;
        step("R3 nmi over external");
        step("R3 nmi held");

        // R10 / R4: every acknowledge code against a fixed pending set
        ext_req = '0;
        for (int a = 0; a < 16; a++) begin
            do_ack(4'(a), "R10 ack sweep");
        end
        step("R6 idle after sweep");

        // R2: reset request dominates and is not latched
        nmi_req = 1'b1;
        ext_req[0] = 1'b1;
        rst_req = 1'b1;
        step("R2 reset wins");
        do_ack(4'd0, "R2 ack of level 0 ignored");
        rst_req = 1'b0;
        step("R2 not latched, nmi next");
        do_ack(4'd2, "R4 ack of reserved level");
        do_ack(4'd1, "R3 ack nmi");
        do_ack(4'd1, "R10 ack nmi when idle");
        do_ack(4'd4, "R6 external cleared");
        nmi_req = 1'b0;
        ext_req = '0;
        step("R6 fully idle");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule